// File: doc/BRIEF.md
# Data address translation checker

This block sits in the load/store path and turns a data virtual address into a physical address, or explains why it cannot. Each request carries the address, an access size, a read/write flag, a physical-access flag, an alternate-mode flag, bit 0 of the current program counter, the data-side privilege mode, the alternate mode value and the current address space number. The checks run in a fixed order: alignment, physical bypass, address validity, the direct-mapped superpage window, and finally a lookup in a small fully associative table of page entries. Each entry holds separate read and write permission masks indexed by privilege mode.

Requests enter on a valid/ready handshake and results leave on a second valid/ready handshake through one output register. A request is taken when `req_valid` and `req_ready` are both high. `req_ready` is high whenever the output register is empty or is being drained in the same cycle. While `rsp_valid` is high and `rsp_ready` is low the result is held unchanged and no new request is taken. Six counters record, separately for reads and writes, how many table lookups, misses and access violations the block has seen. Entries are written through a plain fill port; walking page tables to produce them is the job of another block.

Top module: `dtrans_checker`

## Requirements
- R1: If the address ANDed with (bytes − 1) is nonzero, the result is an alignment fault (code 1), whatever the other flags say. Size code s means 2^s bytes (0..3). The status word then holds only the write bit. Status bits: bit 0 write, bit 1 violation, bit 2 bad address.
- R2: The effective mode used for permission checks is the data mode when PC bit 0 is 0. When PC bit 0 is 1 it is the alternate mode if the alternate flag is set, and kernel mode otherwise. Modes are kernel 0, exec 1, supervisor 2, user 3.
- R3: An aligned request flagged physical returns the address unchanged, fault 0, and updates no counter.
- R4: If bits 63:42 of a virtual address are neither all zeros nor all ones, the result is a bad-address fault (code 2). Its status has the bad-address and violation bits set, plus the write bit for a store, and the read or write violation counter is incremented.
- R5: A valid address whose bits 47:41 equal 0x7e, requested in data mode kernel, returns the address masked to its low 44 bits with fault 0, and no counter changes.
- R6: The same superpage request in any data mode other than kernel is an access violation (code 3), with status holding the violation and write bits. It is judged on the data mode, not the effective mode. The violation counter is incremented.
- R7: Any other valid address increments the read or write access counter and is looked up by bits 42:13 and the address space number. On a hit with permission, the result is {ppn, address bits 12:0} with fault 0 and status 0.
- R8: A lookup that matches no valid entry is a miss (code 4) with only the write bit in the status, and increments the miss counter for its direction.
- R9: A hit whose read mask (for a load) or write mask (for a store) has a 0 at the effective mode's bit is an access violation (code 3), with the violation and write bits in the status, and increments the violation counter.
- R10: An entry matches only when both its page number and its address space number equal the request's.
- R11: A request is accepted exactly when req_valid and req_ready are high. Its result appears with rsp_valid on the next cycle. While rsp_valid is high and rsp_ready low, the result stays stable and req_ready is low.
- R12: A fill and a lookup of the same entry in the same cycle: the lookup sees the entry's old contents, and the new contents serve the next request.
- R13: After reset rsp_valid is 0, req_ready is 1, all entries are invalid and all six counters read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be taken |
| req_va | input | 64 | Virtual address |
| req_size | input | 2 | Log2 of access size in bytes |
| req_write | input | 1 | 1 for store, 0 for load |
| req_phys | input | 1 | Physical access, skip translation |
| req_alt | input | 1 | Use alternate mode when in privileged code |
| cur_pc_lsb | input | 1 | Bit 0 of the current program counter |
| data_mode | input | 2 | Current data privilege mode |
| alt_mode | input | 2 | Alternate mode value |
| cur_asn | input | 8 | Address space number |
| rsp_valid | output | 1 | Result present |
| rsp_ready | input | 1 | Result taken by consumer |
| rsp_pa | output | 64 | Physical address (0 on a fault) |
| rsp_fault | output | 3 | Fault code |
| rsp_status | output | 3 | Status flags: write, violation, bad address |
| fill_en | input | 1 | Write an entry |
| fill_idx | input | 3 | Entry index to write |
| fill_vpn | input | 30 | Virtual page number (address bits 42:13) |
| fill_asn | input | 8 | Address space number of the entry |
| fill_ppn | input | 31 | Physical page number |
| fill_rd_mask | input | 4 | Modes allowed to read, bit per mode |
| fill_wr_mask | input | 4 | Modes allowed to write, bit per mode |
| rd_acc_cnt | output | 16 | Load lookups |
| wr_acc_cnt | output | 16 | Store lookups |
| rd_miss_cnt | output | 16 | Load misses |
| wr_miss_cnt | output | 16 | Store misses |
| rd_viol_cnt | output | 16 | Load violations and bad addresses |
| wr_viol_cnt | output | 16 | Store violations and bad addresses |

## Verification
The two functions that can meet in one cycle are an entry fill and a lookup that targets the very entry being written. The bench starts a fill of a previously empty slot and an accepted load to that page on the same clock edge. It expects a miss for that load, then sends the identical load again and expects a hit carrying the new physical page. A second overlap, result back-pressure against new acceptance, is provoked by a randomly withheld `rsp_ready` and judged by requiring the held result to stay stable.

// File: rtl/dtrans_pkg.sv
package dtrans_pkg;

  typedef enum logic [2:0] {
    FLT_NONE  = 3'd0,
    FLT_ALIGN = 3'd1,
    FLT_BADVA = 3'd2,
    FLT_ACV   = 3'd3,
    FLT_MISS  = 3'd4
  } flt_e;

  localparam logic [1:0] MODE_KERNEL = 2'd0;

  // status word bit positions
  localparam int ST_WR   = 0;
  localparam int ST_VIOL = 1;
  localparam int ST_BAD  = 2;

  // direct-mapped window tag
  localparam int         SP_HI  = 47;
  localparam int         SP_LO  = 41;
  localparam logic [6:0] SP_TAG = 7'h7e;

  // counter bank slots
  localparam int N_CNT       = 6;
  localparam int CNT_RD_ACC  = 0;
  localparam int CNT_WR_ACC  = 1;
  localparam int CNT_RD_MISS = 2;
  localparam int CNT_WR_MISS = 3;
  localparam int CNT_RD_VIOL = 4;
  localparam int CNT_WR_VIOL = 5;

endpackage

// File: rtl/dtrans_mode_sel.sv
module dtrans_mode_sel
  import dtrans_pkg::*;
(
  input  logic       priv_pc,
  input  logic       alt_req,
  input  logic [1:0] data_mode,
  input  logic [1:0] alt_mode,
  output logic [1:0] eff_mode
);

  // R2: privileged code may borrow the alternate mode
  always_comb begin
    if (!priv_pc)     eff_mode = data_mode;
    else if (alt_req) eff_mode = alt_mode;
    else              eff_mode = MODE_KERNEL;
  end

endmodule

// File: rtl/dtrans_entry_array.sv
module dtrans_entry_array #(
  parameter int ENTRIES = 8,
  parameter int IDX_W   = 3,
  parameter int VPN_W   = 30,
  parameter int ASN_W   = 8,
  parameter int PPN_W   = 31,
  parameter int MODES   = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fill_en,
  input  logic [IDX_W-1:0] fill_idx,
  input  logic [VPN_W-1:0] fill_vpn,
  input  logic [ASN_W-1:0] fill_asn,
  input  logic [PPN_W-1:0] fill_ppn,
  input  logic [MODES-1:0] fill_rd,
  input  logic [MODES-1:0] fill_wr,
  input  logic [VPN_W-1:0] look_vpn,
  input  logic [ASN_W-1:0] look_asn,
  output logic             hit,
  output logic [PPN_W-1:0] hit_ppn,
  output logic [MODES-1:0] hit_rd,
  output logic [MODES-1:0] hit_wr
);

  logic             vld_q [ENTRIES];
  logic [VPN_W-1:0] vpn_q [ENTRIES];
  logic [ASN_W-1:0] asn_q [ENTRIES];
  logic [PPN_W-1:0] ppn_q [ENTRIES];
  logic [MODES-1:0] rd_q  [ENTRIES];
  logic [MODES-1:0] wr_q  [ENTRIES];
  logic [ENTRIES-1:0] match;

  for (genvar i = 0; i < ENTRIES; i++) begin : g_ent
    logic sel;
    assign sel = fill_en && (fill_idx == IDX_W'(i));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   vld_q[i] <= 1'b0;
      else if (sel) vld_q[i] <= 1'b1;
    end

    always_ff @(posedge clk) begin
      if (sel) begin
        vpn_q[i] <= fill_vpn;
        asn_q[i] <= fill_asn;
        ppn_q[i] <= fill_ppn;
        rd_q[i]  <= fill_rd;
        wr_q[i]  <= fill_wr;
      end
    end

    // R10: page number and address space must both agree
    assign match[i] = vld_q[i] && (vpn_q[i] == look_vpn) && (asn_q[i] == look_asn);
  end

  // lowest matching index wins
  always_comb begin
    hit     = 1'b0;
    hit_ppn = '0;
    hit_rd  = '0;
    hit_wr  = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (match[i]) begin
        hit     = 1'b1;
        hit_ppn = ppn_q[i];
        hit_rd  = rd_q[i];
        hit_wr  = wr_q[i];
      end
    end
  end

endmodule

// File: rtl/dtrans_fault_eval.sv
module dtrans_fault_eval
  import dtrans_pkg::*;
#(
  parameter int VA_W       = 64,
  parameter int VALID_BITS = 43,
  parameter int PAGE_SHIFT = 13,
  parameter int PA_W       = 44,
  parameter int PPN_W      = 31,
  parameter int MODES      = 4
) (
  input  logic [VA_W-1:0]  va,
  input  logic [1:0]       size_lg,
  input  logic             wr,
  input  logic             phys,
  input  logic [1:0]       data_mode,
  input  logic [1:0]       eff_mode,
  input  logic             hit,
  input  logic [PPN_W-1:0] hit_ppn,
  input  logic [MODES-1:0] hit_rd,
  input  logic [MODES-1:0] hit_wr,
  output flt_e             fault,
  output logic [2:0]       status,
  output logic [VA_W-1:0]  pa,
  output logic             inc_acc,
  output logic             inc_miss,
  output logic             inc_viol
);

  localparam int EXT_W = VA_W - VALID_BITS + 1;
  localparam logic [VA_W-1:0] PA_MASK = {{(VA_W-PA_W){1'b0}}, {PA_W{1'b1}}};

  logic [2:0]       low_mask;
  logic             misalign;
  logic [EXT_W-1:0] ext;
  logic             va_ok;
  logic             in_sp;
  logic             perm;

  always_comb begin
    case (size_lg)
      2'd0:    low_mask = 3'b000;
      2'd1:    low_mask = 3'b001;
      2'd2:    low_mask = 3'b011;
      default: low_mask = 3'b111;
    endcase
  end

  assign misalign = |(va[2:0] & low_mask);
  assign ext      = va[VA_W-1:VALID_BITS-1];
  assign va_ok    = (&ext) || !(|ext);
  assign in_sp    = (va[SP_HI:SP_LO] == SP_TAG);
  assign perm     = wr ? hit_wr[eff_mode] : hit_rd[eff_mode];

  always_comb begin
    fault    = FLT_NONE;
    status   = '0;
    pa       = '0;
    inc_acc  = 1'b0;
    inc_miss = 1'b0;
    inc_viol = 1'b0;
    if (misalign) begin                         // R1
      fault          = FLT_ALIGN;
      status[ST_WR]  = wr;
    end else if (phys) begin                    // R3
      pa             = va;
    end else if (!va_ok) begin                  // R4
      fault          = FLT_BADVA;
      status[ST_WR]  = wr;
      status[ST_VIOL]= 1'b1;
      status[ST_BAD] = 1'b1;
      inc_viol       = 1'b1;
    end else if (in_sp) begin
      if (data_mode != MODE_KERNEL) begin       // R6
        fault          = FLT_ACV;
        status[ST_WR]  = wr;
        status[ST_VIOL]= 1'b1;
        inc_viol       = 1'b1;
      end else begin                            // R5
        pa = va & PA_MASK;
      end
    end else begin
      inc_acc = 1'b1;                           // R7
      if (!hit) begin                           // R8
        fault         = FLT_MISS;
        status[ST_WR] = wr;
        inc_miss      = 1'b1;
      end else if (!perm) begin                 // R9
        fault          = FLT_ACV;
        status[ST_WR]  = wr;
        status[ST_VIOL]= 1'b1;
        inc_viol       = 1'b1;
      end else begin
        pa = {{(VA_W-PA_W){1'b0}}, hit_ppn, va[PAGE_SHIFT-1:0]};
      end
    end
  end

endmodule

// File: rtl/dtrans_counter_bank.sv
module dtrans_counter_bank #(
  parameter int N = 6,
  parameter int W = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [N-1:0]        inc,
  output logic [N-1:0][W-1:0] cnt
);

  for (genvar i = 0; i < N; i++) begin : g_cnt
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      cnt[i] <= '0;
      else if (inc[i]) cnt[i] <= cnt[i] + W'(1);
    end
  end

endmodule

// File: rtl/dtrans_checker.sv
module dtrans_checker
  import dtrans_pkg::*;
#(
  parameter int VA_W       = 64,
  parameter int VALID_BITS = 43,
  parameter int PAGE_SHIFT = 13,
  parameter int PA_W       = 44,
  parameter int ASN_W      = 8,
  parameter int ENTRIES    = 8,
  parameter int CNT_W      = 16,
  localparam int IDX_W     = (ENTRIES > 1) ? $clog2(ENTRIES) : 1,
  localparam int VPN_W     = VALID_BITS - PAGE_SHIFT,
  localparam int PPN_W     = PA_W - PAGE_SHIFT,
  localparam int MODES     = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [VA_W-1:0]  req_va,
  input  logic [1:0]       req_size,
  input  logic             req_write,
  input  logic             req_phys,
  input  logic             req_alt,
  input  logic             cur_pc_lsb,
  input  logic [1:0]       data_mode,
  input  logic [1:0]       alt_mode,
  input  logic [ASN_W-1:0] cur_asn,
  output logic             rsp_valid,
  input  logic             rsp_ready,
  output logic [VA_W-1:0]  rsp_pa,
  output logic [2:0]       rsp_fault,
  output logic [2:0]       rsp_status,
  input  logic             fill_en,
  input  logic [IDX_W-1:0] fill_idx,
  input  logic [VPN_W-1:0] fill_vpn,
  input  logic [ASN_W-1:0] fill_asn,
  input  logic [PPN_W-1:0] fill_ppn,
  input  logic [MODES-1:0] fill_rd_mask,
  input  logic [MODES-1:0] fill_wr_mask,
  output logic [CNT_W-1:0] rd_acc_cnt,
  output logic [CNT_W-1:0] wr_acc_cnt,
  output logic [CNT_W-1:0] rd_miss_cnt,
  output logic [CNT_W-1:0] wr_miss_cnt,
  output logic [CNT_W-1:0] rd_viol_cnt,
  output logic [CNT_W-1:0] wr_viol_cnt
);

  logic [1:0]       eff_mode;
  logic             hit;
  logic [PPN_W-1:0] hit_ppn;
  logic [MODES-1:0] hit_rd, hit_wr;
  flt_e             fault_d;
  logic [2:0]       status_d;
  logic [VA_W-1:0]  pa_d;
  logic             inc_acc, inc_miss, inc_viol;
  logic             accept;
  logic [N_CNT-1:0] inc;
  logic [N_CNT-1:0][CNT_W-1:0] cnt;

  logic             vld_q;
  flt_e             fault_q;
  logic [2:0]       status_q;
  logic [VA_W-1:0]  pa_q;

  dtrans_mode_sel u_mode (
    .priv_pc   (cur_pc_lsb),
    .alt_req   (req_alt),
    .data_mode (data_mode),
    .alt_mode  (alt_mode),
    .eff_mode  (eff_mode)
  );

  dtrans_entry_array #(
    .ENTRIES (ENTRIES), .IDX_W (IDX_W), .VPN_W (VPN_W),
    .ASN_W (ASN_W), .PPN_W (PPN_W), .MODES (MODES)
  ) u_ents (
    .clk      (clk),
    .rst_n    (rst_n),
    .fill_en  (fill_en),
    .fill_idx (fill_idx),
    .fill_vpn (fill_vpn),
    .fill_asn (fill_asn),
    .fill_ppn (fill_ppn),
    .fill_rd  (fill_rd_mask),
    .fill_wr  (fill_wr_mask),
    .look_vpn (req_va[VALID_BITS-1:PAGE_SHIFT]),
    .look_asn (cur_asn),
    .hit      (hit),
    .hit_ppn  (hit_ppn),
    .hit_rd   (hit_rd),
    .hit_wr   (hit_wr)
  );

  dtrans_fault_eval #(
    .VA_W (VA_W), .VALID_BITS (VALID_BITS), .PAGE_SHIFT (PAGE_SHIFT),
    .PA_W (PA_W), .PPN_W (PPN_W), .MODES (MODES)
  ) u_eval (
    .va        (req_va),
    .size_lg   (req_size),
    .wr        (req_write),
    .phys      (req_phys),
    .data_mode (data_mode),
    .eff_mode  (eff_mode),
    .hit       (hit),
    .hit_ppn   (hit_ppn),
    .hit_rd    (hit_rd),
    .hit_wr    (hit_wr),
    .fault     (fault_d),
    .status    (status_d),
    .pa        (pa_d),
    .inc_acc   (inc_acc),
    .inc_miss  (inc_miss),
    .inc_viol  (inc_viol)
  );

  // R11: one output register, drained and refilled in the same cycle
  assign req_ready = !vld_q || rsp_ready;
  assign accept    = req_valid && req_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q    <= 1'b0;
      fault_q  <= FLT_NONE;
      status_q <= '0;
      pa_q     <= '0;
    end else if (accept) begin
      vld_q    <= 1'b1;
      fault_q  <= fault_d;
      status_q <= status_d;
      pa_q     <= pa_d;
    end else if (rsp_ready) begin
      vld_q    <= 1'b0;
    end
  end

  assign rsp_valid  = vld_q;
  assign rsp_fault  = fault_q;
  assign rsp_status = status_q;
  assign rsp_pa     = pa_q;

  always_comb begin
    inc              = '0;
    inc[CNT_RD_ACC]  = accept && inc_acc  && !req_write;
    inc[CNT_WR_ACC]  = accept && inc_acc  &&  req_write;
    inc[CNT_RD_MISS] = accept && inc_miss && !req_write;
    inc[CNT_WR_MISS] = accept && inc_miss &&  req_write;
    inc[CNT_RD_VIOL] = accept && inc_viol && !req_write;
    inc[CNT_WR_VIOL] = accept && inc_viol &&  req_write;
  end

  dtrans_counter_bank #(.N (N_CNT), .W (CNT_W)) u_cnt (
    .clk   (clk),
    .rst_n (rst_n),
    .inc   (inc),
    .cnt   (cnt)
  );

  assign rd_acc_cnt  = cnt[CNT_RD_ACC];
  assign wr_acc_cnt  = cnt[CNT_WR_ACC];
  assign rd_miss_cnt = cnt[CNT_RD_MISS];
  assign wr_miss_cnt = cnt[CNT_WR_MISS];
  assign rd_viol_cnt = cnt[CNT_RD_VIOL];
  assign wr_viol_cnt = cnt[CNT_WR_VIOL];

endmodule

// File: rtl/dtrans_checker_sva.sv
module dtrans_checker_sva #(
  parameter int VA_W  = 64,
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic             req_ready,
  input logic             rsp_valid,
  input logic             rsp_ready,
  input logic [VA_W-1:0]  rsp_pa,
  input logic [2:0]       rsp_fault,
  input logic [2:0]       rsp_status,
  input logic [CNT_W-1:0] rd_acc_cnt,
  input logic [CNT_W-1:0] wr_acc_cnt,
  input logic [CNT_W-1:0] rd_miss_cnt,
  input logic [CNT_W-1:0] wr_miss_cnt
);

  assert_accept_resp_R11: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready |=> rsp_valid);

  assert_stall_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_pa) && $stable(rsp_fault) && $stable(rsp_status));

  assert_stall_block_R11: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |-> !req_ready);

  assert_align_status_R1: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_fault == 3'd1 |-> rsp_status[2:1] == 2'b00 && rsp_pa == '0);

  assert_badva_status_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_fault == 3'd2 |-> rsp_status[2:1] == 2'b11);

  assert_acv_status_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_fault == 3'd3 |-> rsp_status[2:1] == 2'b01);

  assert_clean_status_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_fault == 3'd0 |-> rsp_status == 3'b000);

  assert_miss_le_acc_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rd_miss_cnt <= rd_acc_cnt && wr_miss_cnt <= wr_acc_cnt);

endmodule

bind dtrans_checker dtrans_checker_sva #(.VA_W (VA_W), .CNT_W (CNT_W)) u_sva (
  .clk         (clk),
  .rst_n       (rst_n),
  .req_valid   (req_valid),
  .req_ready   (req_ready),
  .rsp_valid   (rsp_valid),
  .rsp_ready   (rsp_ready),
  .rsp_pa      (rsp_pa),
  .rsp_fault   (rsp_fault),
  .rsp_status  (rsp_status),
  .rd_acc_cnt  (rd_acc_cnt),
  .wr_acc_cnt  (wr_acc_cnt),
  .rd_miss_cnt (rd_miss_cnt),
  .wr_miss_cnt (wr_miss_cnt)
);

// File: tb/sim_dtrans_checker.sv
`timescale 1ns/1ps
module sim_dtrans_checker;

  typedef struct {
    logic [63:0] pa;
    logic [2:0]  fault;
    logic [2:0]  st;
    string       tag;
  } exp_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_ready;
  logic [63:0] req_va = '0;
  logic [1:0] req_size = '0;
  logic req_write = 1'b0, req_phys = 1'b0, req_alt = 1'b0, cur_pc_lsb = 1'b0;
  logic [1:0] data_mode = '0, alt_mode = '0;
  logic [7:0] cur_asn = '0;
  logic rsp_valid, rsp_ready = 1'b1;
  logic [63:0] rsp_pa;
  logic [2:0] rsp_fault, rsp_status;
  logic fill_en = 1'b0;
  logic [2:0] fill_idx = '0;
  logic [29:0] fill_vpn = '0;
  logic [7:0] fill_asn = '0;
  logic [30:0] fill_ppn = '0;
  logic [3:0] fill_rd_mask = '0, fill_wr_mask = '0;
  logic [15:0] cnt_o [6];

  always #2 clk = ~clk;

  dtrans_checker u0 (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_va(req_va), .req_size(req_size),
    .req_write(req_write), .req_phys(req_phys), .req_alt(req_alt), .cur_pc_lsb(cur_pc_lsb),
    .data_mode(data_mode), .alt_mode(alt_mode), .cur_asn(cur_asn),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_pa(rsp_pa), .rsp_fault(rsp_fault),
    .rsp_status(rsp_status),
    .fill_en(fill_en), .fill_idx(fill_idx), .fill_vpn(fill_vpn), .fill_asn(fill_asn),
    .fill_ppn(fill_ppn), .fill_rd_mask(fill_rd_mask), .fill_wr_mask(fill_wr_mask),
    .rd_acc_cnt(cnt_o[0]), .wr_acc_cnt(cnt_o[1]), .rd_miss_cnt(cnt_o[2]),
    .wr_miss_cnt(cnt_o[3]), .rd_viol_cnt(cnt_o[4]), .wr_viol_cnt(cnt_o[5])
  );

  int n_chk = 0, n_bad = 0;
  bit finished = 0;
  bit bp_on = 0;
  exp_t q[$];
  int ex_cnt [6];

  logic        sh_v   [8];
  logic [29:0] sh_vpn [8];
  logic [7:0]  sh_asn [8];
  logic [30:0] sh_ppn [8];
  logic [3:0]  sh_rd  [8];
  logic [3:0]  sh_wr  [8];

  task automatic check(input bit ok, input string tag, input string act, input string exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %s expected %s", tag, act, exp);
    end
  endtask

  // expected result from the requirements
  task automatic model(input logic [63:0] va, input logic [1:0] sz, input logic w, ph, al, pcb,
                       input logic [1:0] dm, am, input logic [7:0] asn, input string tag);
    exp_t e;
    logic [1:0] effm;
    int hi;
    logic ok;
    e.pa = '0; e.fault = 3'd0; e.st = 3'b000; e.tag = tag;
    effm = pcb ? (al ? am : 2'd0) : dm;
    hi = -1;
    if ((va & ((64'd1 << sz) - 64'd1)) != 0) begin
      e.fault = 3'd1; e.st = {2'b00, w};
    end else if (ph) begin
      e.pa = va;
    end else if (!(va[63:42] == '0 || va[63:42] == '1)) begin
      e.fault = 3'd2; e.st = {2'b11, w}; ex_cnt[w ? 5 : 4]++;
    end else if (va[47:41] == 7'h7e) begin
      if (dm != 2'd0) begin
        e.fault = 3'd3; e.st = {2'b01, w}; ex_cnt[w ? 5 : 4]++;
      end else begin
        e.pa = va & 64'h0000_0FFF_FFFF_FFFF;
      end
    end else begin
      ex_cnt[w ? 1 : 0]++;
      for (int i = 7; i >= 0; i--)
        if (sh_v[i] && sh_vpn[i] == va[42:13] && sh_asn[i] == asn) hi = i;
      if (hi < 0) begin
        e.fault = 3'd4; e.st = {2'b00, w}; ex_cnt[w ? 3 : 2]++;
      end else begin
        ok = w ? sh_wr[hi][effm] : sh_rd[hi][effm];
        if (!ok) begin
          e.fault = 3'd3; e.st = {2'b01, w}; ex_cnt[w ? 5 : 4]++;
        end else begin
          e.pa = {20'd0, sh_ppn[hi], va[12:0]};
        end
      end
    end
    q.push_back(e);
  endtask

  // driver: called at a falling edge
  task automatic send(input logic [63:0] va, input logic [1:0] sz, input logic w, ph, al, pcb,
                      input logic [1:0] dm, am, input logic [7:0] asn, input string tag);
    req_va = va; req_size = sz; req_write = w; req_phys = ph; req_alt = al;
    cur_pc_lsb = pcb; data_mode = dm; alt_mode = am; cur_asn = asn; req_valid = 1'b1;
    while (!req_ready) @(negedge clk);
    model(va, sz, w, ph, al, pcb, dm, am, asn, tag);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic fill(input int idx, input logic [29:0] vpn, input logic [7:0] asn,
                      input logic [30:0] ppn, input logic [3:0] rm, wm);
    fill_en = 1'b1; fill_idx = idx[2:0]; fill_vpn = vpn; fill_asn = asn;
    fill_ppn = ppn; fill_rd_mask = rm; fill_wr_mask = wm;
    @(posedge clk);
    #1;
    sh_v[idx] = 1'b1; sh_vpn[idx] = vpn; sh_asn[idx] = asn;
    sh_ppn[idx] = ppn; sh_rd[idx] = rm; sh_wr[idx] = wm;
    @(negedge clk);
    fill_en = 1'b0;
  endtask

  task automatic drain();
    while (q.size() != 0 || rsp_valid) @(negedge clk);
  endtask

  // result back-pressure pattern
  always @(posedge clk) begin
    #1;
    rsp_ready = bp_on ? ($urandom_range(0, 2) != 0) : 1'b1;
  end

  // monitor / scoreboard
  bit hold_p = 0;
  logic [63:0] hold_pa;
  logic [2:0] hold_f, hold_s;
  always @(negedge clk) begin
    if (rst_n) begin
      if (hold_p)
        check(rsp_valid && rsp_pa == hold_pa && rsp_fault == hold_f && rsp_status == hold_s,
              "R11 held result",
              $sformatf("v=%b pa=%h f=%0d s=%b", rsp_valid, rsp_pa, rsp_fault, rsp_status),
              $sformatf("v=1 pa=%h f=%0d s=%b", hold_pa, hold_f, hold_s));
      hold_p = rsp_valid && !rsp_ready;
      hold_pa = rsp_pa; hold_f = rsp_fault; hold_s = rsp_status;
      if (rsp_valid && rsp_ready) begin
        if (q.size() == 0) begin
          check(1'b0, "R11 unexpected result", $sformatf("pa=%h", rsp_pa), "none");
        end else begin
          exp_t e;
          e = q.pop_front();
          check(rsp_pa == e.pa && rsp_fault == e.fault && rsp_status == e.st, e.tag,
                $sformatf("pa=%h f=%0d s=%b", rsp_pa, rsp_fault, rsp_status),
                $sformatf("pa=%h f=%0d s=%b", e.pa, e.fault, e.st));
        end
      end
    end
  end

  function automatic logic [63:0] vaof(input logic [29:0] vpn, input logic [12:0] off);
    return 64'({vpn, off});
  endfunction

  localparam logic [63:0] SPVA  = 64'hFFFF_FC12_3456_7890;
  localparam logic [63:0] BADVA = 64'h0000_1000_0000_0040;
  localparam logic [29:0] VA_A = 30'h0000_1234, VA_B = 30'h0abc_0001, VA_C = 30'h0000_0777;
  localparam logic [29:0] VA_D = 30'h0155_0002;

  initial begin
    for (int i = 0; i < 8; i++) sh_v[i] = 1'b0;
    for (int i = 0; i < 6; i++) ex_cnt[i] = 0;
    repeat (3) @(negedge clk);
    // R13: reset state
    check(rsp_valid == 1'b0 && req_ready == 1'b1, "R13 reset handshake",
          $sformatf("v=%b r=%b", rsp_valid, req_ready), "v=0 r=1");
    rst_n = 1'b1;
    @(negedge clk);
    for (int i = 0; i < 6; i++)
      check(cnt_o[i] == 16'd0, "R13 counter clear", $sformatf("%0d", cnt_o[i]), "0");
    send(vaof(VA_A, 13'h10), 2'd3, 1'b0, 1'b0, 1'b0, 1'b0, 2'd0, 2'd0, 8'd5, "R13 empty table miss");

    fill(0, VA_A, 8'd5, 31'h1234_5678, 4'b1111, 4'b0001);
    fill(1, VA_B, 8'd5, 31'h0000_0abc, 4'b0001, 4'b0000);

    // R1 alignment, including over the physical and bad-address paths
    send(vaof(VA_A, 13'h4), 2'd3, 1'b1, 1'b0, 1'b0, 1'b0, 2'd0, 2'd0, 8'd5, "R1 store 8B misaligned");
    send(vaof(VA_A, 13'h1), 2'd1, 1'b0, 1'b0, 1'b0, 1'b0, 2'd0, 2'd0, 8'd5, "R1 load 2B odd");
    send(64'h0000_0000_0000_0003, 2'd2, 1'b0, 1'b1, 1'b0, 1'b0, 2'd0, 2'd0, 8'd5, "R1 beats physical");
    send(BADVA | 64'h2, 2'd2, 1'b1, 1'b0, 1'b0, 1'b0, 2'd0, 2'd0, 8'd5, "R1 beats bad address");
    send(vaof(VA_A, 13'h7), 2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 2'd0, 2'd0, 8'd5, "R7 byte any offset");
    // R3 physical
    send(64'hDEAD_BEEF_0000_1230, 2'd3, 1'b1, 1'b1, 1'b0, 1'b0, 2'd3, 2'd0, 8'd5, "R3 physical bypass");
    // R4 bad address
    send(BADVA, 2'd3, 1'b1, 1'b0, 1'b0, 1'b0, 2'd0, 2'd0, 8'd5, "R4 bad address store");
    send(64'hFFFF_0000_0000_0000, 2'd3, 1'b0, 1'b0, 1'b0, 1'b0, 2'd0, 2'd0, 8'd5, "R4 bad address load");
    // R5 / R6 superpage
    send(SPVA, 2'd3, 1'b0, 1'b0, 1'b0, 1'b0, 2'd0, 2'd0, 8'd5, "R5 superpage kernel");
    send(SPVA, 2'd3, 1'b1, 1'b0, 1'b0, 1'b0, 2'd3, 2'd0, 8'd5, "R6 superpage user store");
    send(SPVA, 2'd3, 1'b0, 1'b0, 1'b0, 1'b1, 2'd2, 2'd0, 8'd5, "R6 data mode not effective");
    send(SPVA, 2'd3, 1'b0, 1'b0, 1'b1, 1'b1, 2'd0, 2'd3, 8'd5, "R6 alt mode ignored");
    // R7 hit, R8 miss, R10 asn
    send(vaof(VA_A, 13'h1238), 2'd3, 1'b0, 1'b0, 1'b0, 1'b0, 2'd3, 2'd0, 8'd5, "R7 user load hit");
    send(vaof(VA_C, 13'h0), 2'd3, 1'b1, 1'b0, 1'b0, 1'b0, 2'd0, 2'd0, 8'd5, "R8 store miss");
    send(vaof(VA_C, 13'h8), 2'd3, 1'b0, 1'b0, 1'b0, 1'b0, 2'd0, 2'd0, 8'd5, "R8 load miss");
    send(vaof(VA_A, 13'h20), 2'd3, 1'b0, 1'b0, 1'b0, 1'b0, 2'd0, 2'd0, 8'd6, "R10 other asn misses");
    // R9 permissions
    send(vaof(VA_A, 13'h40), 2'd3, 1'b1, 1'b0, 1'b0, 1'b0, 2'd3, 2'd0, 8'd5, "R9 user store denied");
    send(vaof(VA_A, 13'h40), 2'd3, 1'b1, 1'b0, 1'b0, 1'b0, 2'd0, 2'd0, 8'd5, "R9 kernel store allowed");
    send(vaof(VA_B, 13'h40), 2'd3, 1'b1, 1'b0, 1'b0, 1'b0, 2'd0, 2'd0, 8'd5, "R9 no writers");
    // R2 effective mode
    send(vaof(VA_B, 13'h100), 2'd2, 1'b0, 1'b0, 1'b0, 1'b1, 2'd3, 2'd3, 8'd5, "R2 privileged kernel");
    send(vaof(VA_B, 13'h100), 2'd2, 1'b0, 1'b0, 1'b1, 1'b1, 2'd0, 2'd3, 8'd5, "R2 alt user denied");
    send(vaof(VA_B, 13'h100), 2'd2, 1'b0, 1'b0, 1'b1, 1'b0, 2'd3, 2'd0, 8'd5, "R2 alt flag unprivileged");
    send(vaof(VA_B, 13'h100), 2'd2, 1'b0, 1'b0, 1'b1, 1'b1, 2'd3, 2'd0, 8'd5, "R2 alt kernel allowed");

    // R11 back-pressure with mixed traffic
    bp_on = 1;
    for (int k = 0; k < 60; k++) begin
      logic [63:0] va;
      logic [1:0] sz;
      sz = 2'($urandom_range(0, 3));
      case (k % 5)
        0: va = vaof(VA_A, 13'($urandom));
        1: va = vaof(VA_B, 13'($urandom));
        2: va = vaof(VA_C, 13'($urandom));
        3: va = SPVA;
        default: va = BADVA;
      endcase
      if (k % 3 != 0) va = va & ~((64'd1 << sz) - 64'd1);
      send(va, sz, 1'($urandom), 1'(k % 11 == 0), 1'($urandom), 1'($urandom),
           2'($urandom), 2'($urandom), 8'd5, "R11 mixed under back-pressure");
    end
    bp_on = 0;
    drain();

    // R12 fill and lookup of the same slot in one cycle
    fork
      fill(2, VA_D, 8'd5, 31'h0055_5555, 4'b1111, 4'b1111);
      send(vaof(VA_D, 13'h18), 2'd3, 1'b0, 1'b0, 1'b0, 1'b0, 2'd0, 2'd0, 8'd5, "R12 same cycle sees old");
    join
    send(vaof(VA_D, 13'h18), 2'd3, 1'b0, 1'b0, 1'b0, 1'b0, 2'd0, 2'd0, 8'd5, "R12 next sees new");
    drain();

    // counter totals (R4 R6 R7 R8 R9 counted; R1 R3 R5 not)
    for (int i = 0; i < 6; i++)
      check(cnt_o[i] == 16'(ex_cnt[i]), $sformatf("R7 R8 R9 counter %0d", i),
            $sformatf("%0d", cnt_o[i]), $sformatf("%0d", ex_cnt[i]));

    if (!finished) begin
      finished = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

endmodule